// File: doc/BRIEF.md
# Local Bus Cycle Termination Controller

This block follows a CPU bus cycle one T-state per clock and decides in which T2 state the cycle ends. A cycle begins with a one-clock start strobe, which marks T1. The clock after it is the first T2, and that state belongs entirely to external logic. At the end of the first T2 the block samples two active-low inputs: an external ready and a local-device claim. What it sees there picks one of three outcomes. External ready ends the cycle at once. A claim alone hands termination to the claiming device for as long as it needs. If neither is asserted, the block finishes the cycle itself with its own ready, after a programmable number of wait states.

The ready seen by the CPU merges the block's own registered ready with the external ready. External ready is passed through only in the T2 states where it is allowed to end the cycle. A one-clock done pulse follows every termination. A flag shows while a claimed cycle is in progress. The clock in which the done pulse is high is already idle, so a new start strobe can be given in that clock.

Top module: `lbt_ctrl`

## Requirements
- R1: After a synchronous reset the block is idle, with `cpu_rdy_n` = 1, `cyc_done` = 0 and `claimed` = 0.
- R2: A clock in which `cyc_start` = 1 while the block is idle is T1, and the next clock is the first T2. During the first T2, `cpu_rdy_n` equals `ext_rdy_n`, and the block never asserts its own ready there.
- R3: If `ext_rdy_n` = 0 at the end of the first T2, the cycle ends there and `cyc_done` = 1 in the next clock.
- R4: If `claim_n` = 0 and `ext_rdy_n` = 1 at the end of the first T2, the cycle is claimed. `claimed` = 1 from the second T2 through the terminating T2, and `cpu_rdy_n` follows `ext_rdy_n`. The cycle ends at the end of the first T2 in which `ext_rdy_n` = 0, with no time limit, and the block never asserts its own ready in a claimed cycle.
- R5: If `claim_n` = 0 and `ext_rdy_n` = 0 at the end of the first T2, the cycle ends as in R3 and `claimed` stays 0.
- R6: If both inputs are high at the end of the first T2, the block drives `cpu_rdy_n` = 0 during exactly T2 number 3+`ws_cfg` when `early_ws_en` = 1, or 4+`ws_cfg` when `early_ws_en` = 0. The cycle ends at the end of that T2. Both settings are sampled at the end of the first T2.
- R7: In an unclaimed cycle, `ext_rdy_n` after the first T2 has no effect on `cpu_rdy_n` or on when the cycle ends.
- R8: `claim_n` has no effect at any time other than the end of the first T2.
- R9: `cyc_start` is ignored while a cycle is in progress. `cyc_done` is high for exactly one clock, and a `cyc_start` in that clock begins a new cycle.
- R10: `cpu_rdy_n` = 1 while idle and during T1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | High for the T1 clock of a new cycle |
| ext_rdy_n | input | 1 | Active-low ready from external logic |
| claim_n | input | 1 | Active-low local-device claim |
| early_ws_en | input | 1 | 1: own ready from the third T2; 0: from the fourth |
| ws_cfg | input | WS_W | Extra wait states added to the own-ready point |
| cpu_rdy_n | output | 1 | Merged active-low ready to the CPU |
| cyc_done | output | 1 | One-clock pulse after the terminating T2 |
| claimed | output | 1 | High while a claimed cycle is in progress |

## Verification
The bench sweeps both early-wait settings, every wait-state count and all four outcomes of the first-T2 sample, including claims that last well past the own-ready point. A design off by one in the wait count would pull `cpu_rdy_n` low one T2 early or late. One that did not let ready win over a simultaneous claim would raise `claimed` and never end the cycle. While the block is busy, the bench toggles the claim, the external ready and the start strobe. A design that sampled the claim twice, or let a late external ready end an unclaimed cycle, would show a wrong ready or done timing. Back-to-back cycles started in the done clock expose a design that needs an extra idle clock.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  // T-state tracking: idle (also covers T1), first T2, claimed T2s, own-wait T2s
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_CLAIM = 2'd2,
    ST_OWN   = 2'd3
  } lbt_state_e;

endpackage

// File: rtl/lbt_seq.sv
module lbt_seq
  import lbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_start,
  input  logic       ext_rdy_n,
  input  logic       claim_n,
  input  logic       own_rdy,
  output lbt_state_e st,
  output logic       enter_own,
  output logic       done_q,
  output logic       claimed_q
);

  lbt_state_e st_nxt;
  logic       term;

  // The first-T2 sample is the only point where claim_n is looked at.
  always_comb begin
    enter_own = (st == ST_FIRST) && ext_rdy_n && claim_n;
    term      = 1'b0;
    st_nxt    = st;
    unique case (st)
      ST_IDLE: begin
        if (cyc_start) st_nxt = ST_FIRST;
      end
      ST_FIRST: begin
        if (!ext_rdy_n) begin
          term   = 1'b1;
          st_nxt = ST_IDLE;
        end else if (!claim_n) begin
          st_nxt = ST_CLAIM;
        end else begin
          st_nxt = ST_OWN;
        end
      end
      ST_CLAIM: begin
        if (!ext_rdy_n) begin
          term   = 1'b1;
          st_nxt = ST_IDLE;
        end
      end
      ST_OWN: begin
        if (own_rdy) begin
          term   = 1'b1;
          st_nxt = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done_q    <= 1'b0;
      claimed_q <= 1'b0;
    end else begin
      st        <= st_nxt;
      done_q    <= term;
      claimed_q <= (st_nxt == ST_CLAIM);
    end
  end

endmodule

// File: rtl/lbt_wait_timer.sv
module lbt_wait_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter_own,
  input  logic            in_own,
  input  logic            early_ws_en,
  input  logic [WS_W-1:0] ws_cfg,
  output logic            own_rdy_q
);

  // Holds 2 + max ws_cfg without wrap
  localparam int CNT_W = WS_W + 2;

  logic [CNT_W-1:0] rem;

  // rem counts T2 states left before the own-ready T2; loaded on entry to T2 #2
  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      own_rdy_q <= 1'b0;
    end else if (enter_own) begin
      rem       <= (early_ws_en ? CNT_W'(1) : CNT_W'(2)) + CNT_W'(ws_cfg);
      own_rdy_q <= 1'b0;
    end else if (in_own && !own_rdy_q) begin
      if (rem == CNT_W'(1)) begin
        rem       <= '0;
        own_rdy_q <= 1'b1;
      end else begin
        rem       <= rem - CNT_W'(1);
      end
    end else begin
      rem       <= '0;
      own_rdy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lbt_rdy_merge.sv
module lbt_rdy_merge
  import lbt_pkg::*;
(
  input  lbt_state_e st,
  input  logic       ext_rdy_n,
  input  logic       own_rdy,
  output logic       cpu_rdy_n
);

  logic ext_window;

  // External ready reaches the CPU only where it may end the cycle
  always_comb begin
    ext_window = (st == ST_FIRST) || (st == ST_CLAIM);
    cpu_rdy_n  = !(own_rdy || (ext_window && !ext_rdy_n));
  end

endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_start,
  input  logic            ext_rdy_n,
  input  logic            claim_n,
  input  logic            early_ws_en,
  input  logic [WS_W-1:0] ws_cfg,
  output logic            cpu_rdy_n,
  output logic            cyc_done,
  output logic            claimed
);

  lbt_state_e st;
  logic       enter_own;
  logic       own_rdy_q;
  logic       in_own;

  assign in_own = (st == ST_OWN);

  lbt_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .ext_rdy_n (ext_rdy_n),
    .claim_n   (claim_n),
    .own_rdy   (own_rdy_q),
    .st        (st),
    .enter_own (enter_own),
    .done_q    (cyc_done),
    .claimed_q (claimed)
  );

  lbt_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .enter_own   (enter_own),
    .in_own      (in_own),
    .early_ws_en (early_ws_en),
    .ws_cfg      (ws_cfg),
    .own_rdy_q   (own_rdy_q)
  );

  lbt_rdy_merge u_merge (
    .st        (st),
    .ext_rdy_n (ext_rdy_n),
    .own_rdy   (own_rdy_q),
    .cpu_rdy_n (cpu_rdy_n)
  );

endmodule

// File: rtl/lbt_chk.sv
module lbt_chk
  import lbt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input lbt_state_e st,
  input logic       ext_rdy_n,
  input logic       claim_n,
  input logic       own_rdy,
  input logic       cpu_rdy_n,
  input logic       cyc_done,
  input logic       claimed
);

  // R2
  first_t2_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRST) |-> !own_rdy);

  // R3
  ext_first_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRST && !ext_rdy_n) |=> (cyc_done && st == ST_IDLE && !claimed));

  // R4
  claim_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRST && ext_rdy_n && !claim_n) |=> claimed);

  // R4
  claim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLAIM && ext_rdy_n) |=> (st == ST_CLAIM && claimed && !cyc_done));

  // R4
  claim_no_own_chk: assert property (@(posedge clk) disable iff (rst)
    claimed |-> !own_rdy);

  // R6
  own_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && own_rdy) |=> (cyc_done && st == ST_IDLE));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> cpu_rdy_n);

endmodule

bind lbt_ctrl lbt_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st),
  .ext_rdy_n (ext_rdy_n),
  .claim_n   (claim_n),
  .own_rdy   (own_rdy_q),
  .cpu_rdy_n (cpu_rdy_n),
  .cyc_done  (cyc_done),
  .claimed   (claimed)
);

// File: tb/tb_lbt_ctrl.sv
module tb_lbt_ctrl;

  localparam int WS_W = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cyc_start = 1'b0;
  logic            ext_rdy_n = 1'b1;
  logic            claim_n = 1'b1;
  logic            early_ws_en = 1'b0;
  logic [WS_W-1:0] ws_cfg = '0;
  logic            cpu_rdy_n;
  logic            cyc_done;
  logic            claimed;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lbt_ctrl #(.WS_W(WS_W)) dut (
    .clk         (clk),
    .rst         (rst),
    .cyc_start   (cyc_start),
    .ext_rdy_n   (ext_rdy_n),
    .claim_n     (claim_n),
    .early_ws_en (early_ws_en),
    .ws_cfg      (ws_cfg),
    .cpu_rdy_n   (cpu_rdy_n),
    .cyc_done    (cyc_done),
    .claimed     (claimed)
  );

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one T-state's inputs after the falling edge, then settle
  task automatic drive(input bit s, input bit e, input bit c);
    @(negedge clk);
    cyc_start = s;
    ext_rdy_n = e;
    claim_n   = c;
    #1;
  endtask

  // mode: 0 ext ready first T2, 1 claim, 2 claim+ready, 3 own ready
  task automatic do_cycle(input int early, input int ws, input int mode, input int k,
                          input bit skip_t1, input bit b2b);
    bit e1;
    bit c1;
    int target;
    early_ws_en = early[0];
    ws_cfg      = ws[WS_W-1:0];
    if (!skip_t1) begin
      drive(1'b1, 1'b1, 1'b1);
      chk(cpu_rdy_n, 1'b1, "R10", "rdy in T1");
      chk(cyc_done, 1'b0, "R9", "done in T1");
    end
    e1 = (mode == 0 || mode == 2) ? 1'b0 : 1'b1;
    c1 = (mode == 1 || mode == 2) ? 1'b0 : 1'b1;
    drive(1'b0, e1, c1);
    chk(cpu_rdy_n, e1, "R2", "rdy in first T2");
    chk(claimed, 1'b0, "R2", "claimed in first T2");
    chk(cyc_done, 1'b0, "R9", "done single pulse");
    if (mode == 1) begin
      for (int i = 1; i <= k; i++) begin
        bit last;
        last = (i == k);
        drive(i[0], last ? 1'b0 : 1'b1, i[0]);
        chk(claimed, 1'b1, "R4", "claimed flag held");
        chk(cpu_rdy_n, last ? 1'b0 : 1'b1, "R4", "rdy in claimed T2");
        chk(cyc_done, 1'b0, "R8", "no early end");
      end
    end else if (mode == 3) begin
      target = (early != 0 ? 3 : 4) + ws;
      for (int n = 2; n <= target; n++) begin
        drive(n == 2, n[0], ~n[0]);
        chk(cpu_rdy_n, (n == target) ? 1'b0 : 1'b1, "R6", "own rdy point");
        chk(claimed, 1'b0, "R8", "claim ignored");
        chk(cyc_done, 1'b0, "R7", "no end by late ext rdy");
      end
    end
    drive(b2b, 1'b1, 1'b1);
    chk(cyc_done, 1'b1, mode == 2 ? "R5" : (mode == 0 ? "R3" : (mode == 1 ? "R4" : "R6")), "done pulse");
    chk(claimed, 1'b0, mode == 2 ? "R5" : "R4", "claimed cleared");
    chk(cpu_rdy_n, 1'b1, "R10", "rdy after end");
  endtask

  initial begin
    bit pend;
    int cnt;
    pend = 0;
    cnt  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_rdy_n, 1'b1, "R1", "reset rdy");
    chk(cyc_done, 1'b0, "R1", "reset done");
    chk(claimed, 1'b0, "R1", "reset claimed");
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    chk(cpu_rdy_n, 1'b1, "R10", "idle ignores ext rdy");
    chk(claimed, 1'b0, "R8", "idle claim ignored");
    for (int early = 0; early < 2; early++) begin
      for (int ws = 0; ws < (1 << WS_W); ws++) begin
        for (int mode = 0; mode < 4; mode++) begin
          int kmax;
          kmax = (mode == 1) ? 4 : 1;
          for (int ki = 1; ki <= kmax; ki++) begin
            int k;
            bit b2b;
            k   = (ki == 4) ? 14 : ki;
            b2b = (cnt % 3 == 1);
            do_cycle(early, ws, mode, k, pend, b2b);
            pend = b2b;
            cnt++;
          end
        end
      end
    end
    if (pend) do_cycle(1, 0, 0, 1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    chk(cyc_done, 1'b0, "R9", "done after last");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule